// File: doc/BRIEF.md
# Oversampling Forwarded-Clock Receiver

This block accepts a slow source-synchronous link, one forwarded clock line plus a parallel data bus, and brings it into a fast, stable local clock domain without ever clocking any flop from the forwarded clock. Every incoming line, the forwarded clock included, goes through the same chain of local-clock synchronizer flops, so the clock line and the data lines stay in step. The synchronized clock line is then treated as data: a level is only believed after it has been seen for a minimum number of consecutive local cycles, and a believed low-to-high change marks a word.

For each accepted rising transition the block issues a one-cycle strobe with a word. The word is the data bus as sampled in the last local cycle in which the forwarded clock was still low, so the value the sender held just before its edge is taken, and a sender that changes its bus at the edge has no effect on the captured word. Departures from the believed level that end before they qualify are thrown away and counted in a saturating counter. If no accepted rising transition turns up for a set number of local cycles, a lost-clock flag goes up, and it drops again with the next strobe. The scheme suits forwarded clocks running well below the local clock rate.

Top module: `oss_rx`

## Requirements
- R1: The forwarded clock and data lines pass through SYNC_STAGES local-clock flops. When the forwarded clock first samples high after a qualified low level and stays high, valid_o rises after the (SYNC_STAGES+MIN_PULSE)-th rising local clock edge counted from the first edge that samples it high.
- R2: valid_o is high for exactly one local cycle for each accepted rising transition, and never for two cycles in a row.
- R3: data_o is the data bus sampled in the same local cycle as the last low sample of the forwarded clock before the accepted rise, delayed by the same synchronizer depth. data_o changes only together with valid_o.
- R4: A high level of the forwarded clock that lasts fewer than MIN_PULSE local cycles yields no strobe and adds one to glitch_cnt_o.
- R5: A low level of the forwarded clock that lasts fewer than MIN_PULSE local cycles inside a qualified high level is ignored: no new strobe follows when the high resumes, and glitch_cnt_o grows by one.
- R6: glitch_cnt_o rises by one per rejected pulse and stays at all ones once it gets there.
- R7: clk_lost_o rises once TIMEOUT local cycles pass without an accepted rising transition since reset or since the last strobe, and drops in the cycle valid_o goes high.
- R8: While rst_ni is low, valid_o, data_o, glitch_cnt_o and clk_lost_o are all zero and the synchronizer, level and run state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast local clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fclk_i | input | 1 | Forwarded clock line, sampled as data |
| fdata_i | input | DATA_W | Forwarded data bus |
| valid_o | output | 1 | One-cycle strobe per accepted rising transition |
| data_o | output | DATA_W | Captured word, held between strobes |
| glitch_cnt_o | output | GLITCH_W | Saturating count of rejected pulses |
| clk_lost_o | output | 1 | Forwarded clock absent for TIMEOUT cycles |

## Verification
The hardest case to reach is a short low dip inside an already qualified high level, because it needs a high that qualified, then a dip of fewer than MIN_PULSE cycles, then a return to high, all aligned against the synchronizer delay. Random half-period lengths that straddle MIN_PULSE produce such dips and short highs in large numbers, and a cycle-level reference model in the bench, written from the requirements, predicts every strobe, word, counter value and flag. Directed sequences then pin down the exact latency, the last-low capture with the bus changing at the edge, counter saturation and a stall longer than the timeout.

// File: rtl/oss_rx_pkg.sv
package oss_rx_pkg;
  typedef struct packed {
    logic rise;    // qualified low-to-high transition
    logic glitch;  // departure from believed level ended unqualified
  } edge_evt_t;
endpackage

// File: rtl/oss_rx_sync.sv
module oss_rx_sync #(
  parameter int unsigned WIDTH  = 9,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/oss_rx_filter.sv
module oss_rx_filter
  import oss_rx_pkg::*;
#(
  parameter int unsigned MIN_PULSE = 3
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      smp_i,
  output edge_evt_t evt_o
);
  localparam int unsigned RUN_W = $clog2(MIN_PULSE + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_PULSE);

  logic             prev_q, lvl_q;
  logic [RUN_W-1:0] run_q, run_d;
  logic             qual;

  // run_d: consecutive cycles the current sample value has held, saturating
  always_comb begin
    if (smp_i != prev_q)     run_d = RUN_W'(1);
    else if (run_q < RUN_MAX) run_d = run_q + RUN_W'(1);
    else                     run_d = run_q;
  end

  assign qual         = (smp_i != lvl_q) && (run_d >= RUN_MAX);
  assign evt_o.rise   = qual && smp_i;
  assign evt_o.glitch = (smp_i != prev_q) && (prev_q != lvl_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lvl_q  <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= smp_i;
      run_q  <= run_d;
      if (qual) lvl_q <= smp_i;
    end
  end
endmodule

// File: rtl/oss_rx_watchdog.sv
module oss_rx_watchdog #(
  parameter int unsigned TIMEOUT = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic kick_i,
  output logic lost_o
);
  localparam int unsigned CNT_W = $clog2(TIMEOUT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      lost_o <= 1'b0;
    end else if (kick_i) begin
      cnt_q  <= '0;
      lost_o <= 1'b0;
    end else if (cnt_q == CNT_LAST) begin
      lost_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/oss_rx.sv
module oss_rx
  import oss_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_PULSE   = 3,
  parameter int unsigned TIMEOUT     = 64,
  parameter int unsigned GLITCH_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                fclk_i,
  input  logic [DATA_W-1:0]   fdata_i,
  output logic                valid_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [GLITCH_W-1:0] glitch_cnt_o,
  output logic                clk_lost_o
);
  localparam int unsigned LANE_W = DATA_W + 1;

  logic [LANE_W-1:0] lane_s;
  logic              smp_clk;
  logic [DATA_W-1:0] smp_data;
  logic [DATA_W-1:0] hold_q;
  edge_evt_t         evt;

  // clock line rides in the same synchronizer as the data to keep alignment
  oss_rx_sync #(.WIDTH(LANE_W), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({fclk_i, fdata_i}),
    .q_o   (lane_s)
  );

  assign smp_clk  = lane_s[LANE_W-1];
  assign smp_data = lane_s[DATA_W-1:0];

  oss_rx_filter #(.MIN_PULSE(MIN_PULSE)) filt_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .smp_i (smp_clk),
    .evt_o (evt)
  );

  oss_rx_watchdog #(.TIMEOUT(TIMEOUT)) wdg_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .kick_i(evt.rise),
    .lost_o(clk_lost_o)
  );

  // hold tracks data while the clock line reads low; frozen while high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       hold_q <= '0;
    else if (!smp_clk) hold_q <= smp_data;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= evt.rise;
      if (evt.rise) data_o <= hold_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            glitch_cnt_o <= '0;
    else if (evt.glitch && !(&glitch_cnt_o)) glitch_cnt_o <= glitch_cnt_o + GLITCH_W'(1);
  end
endmodule

// File: rtl/oss_rx_chk.sv
module oss_rx_chk #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned GLITCH_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                sync_clk_i,
  input logic                valid_o,
  input logic [DATA_W-1:0]   data_o,
  input logic [GLITCH_W-1:0] glitch_cnt_o,
  input logic                clk_lost_o
);
  // R2
  valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R4
  valid_needs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sync_clk_i));

  // R3
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));

  // R6
  glitch_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (glitch_cnt_o != $past(glitch_cnt_o)) |-> (glitch_cnt_o == $past(glitch_cnt_o) + 1'b1));

  // R6
  glitch_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&$past(glitch_cnt_o)) |-> (&glitch_cnt_o));

  // R7
  lost_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !clk_lost_o);

  // R7
  lost_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_lost_o) |-> !valid_o);
endmodule

bind oss_rx oss_rx_chk #(.DATA_W(DATA_W), .GLITCH_W(GLITCH_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sync_clk_i  (smp_clk),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .glitch_cnt_o(glitch_cnt_o),
  .clk_lost_o  (clk_lost_o)
);

// File: tb/oss_rx_tb_top.sv
module oss_rx_tb_top;
  localparam int unsigned DW = 8;
  localparam int unsigned S  = 2;
  localparam int unsigned MP = 3;
  localparam int unsigned TO = 40;
  localparam int unsigned GW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          fclk = 1'b0;
  logic [DW-1:0] fdata = '0;
  logic          valid;
  logic [DW-1:0] data;
  logic [GW-1:0] gcnt;
  logic          lost;

  int n_chk = 0;
  int n_fail = 0;
  int n_valid = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  oss_rx #(.DATA_W(DW), .SYNC_STAGES(S), .MIN_PULSE(MP), .TIMEOUT(TO), .GLITCH_W(GW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fclk_i(fclk), .fdata_i(fdata),
    .valid_o(valid), .data_o(data), .glitch_cnt_o(gcnt), .clk_lost_o(lost)
  );

  // reference model built from the requirements
  logic [S-1:0]         m_x;
  logic [S-1:0][DW-1:0] m_d;
  logic                 m_prev, m_lvl, m_valid, m_lost;
  int                   m_run, m_idle;
  logic [DW-1:0]        m_hold, m_data;
  logic [GW-1:0]        m_gl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_x = '0; m_d = '0; m_prev = 0; m_lvl = 0; m_valid = 0; m_lost = 0;
      m_run = 0; m_idle = 0; m_hold = '0; m_data = '0; m_gl = '0;
    end else begin
      logic fs;
      logic [DW-1:0] ds;
      logic qual;
      fs = m_x[S-1];
      ds = m_d[S-1];
      if (fs != m_prev) m_run = 1;
      else if (m_run < MP) m_run = m_run + 1;
      qual = (fs != m_lvl) && (m_run >= MP);
      if (fs != m_prev && m_prev != m_lvl && m_gl != '1) m_gl = m_gl + 1'b1;
      m_valid = qual && fs;
      if (m_valid) m_data = m_hold;
      if (!fs) m_hold = ds;
      if (qual) m_lvl = fs;
      if (m_valid) m_idle = 0;
      else if (m_idle < TO) m_idle = m_idle + 1;
      m_lost = (m_idle >= TO);
      m_prev = fs;
      m_x = {m_x[S-2:0], fclk};
      m_d = {m_d[S-2:0], fdata};
    end
  end

  function automatic void check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endfunction

  always @(negedge clk) begin
    if (valid) n_valid++;
    if (cmp_en && rst_n) begin
      check(valid == m_valid, "R2 valid", valid, m_valid);
      check(data == m_data, "R3 data", data, m_data);
      check(gcnt == m_gl, "R4 glitch count", gcnt, m_gl);
      check(lost == m_lost, "R7 lost flag", lost, m_lost);
    end
  end

  task automatic drive(input logic x, input logic [DW-1:0] d);
    @(negedge clk);
    fclk = x;
    fdata = d;
  endtask

  task automatic hold_level(input logic x, input logic [DW-1:0] d, input int n);
    for (int i = 0; i < n; i++) drive(x, d);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int v0;
    int g0;
    void'($urandom(32'd20240601));
    // R8 reset state
    repeat (3) @(negedge clk);
    check(valid == 0 && data == 0 && gcnt == 0 && lost == 0, "R8 reset", {valid, lost, gcnt}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // random half-periods straddling MIN_PULSE; bus changes only at the rise
    for (int p = 0; p < 400; p++) begin
      int lo_n, hi_n;
      lo_n = 1 + int'($urandom_range(5));
      hi_n = 1 + int'($urandom_range(5));
      hold_level(1'b0, fdata, lo_n);
      drive(1'b1, DW'($urandom));
      hold_level(1'b1, fdata, hi_n - 1);
    end

    // R8 reset in mid traffic
    drive(1'b1, 8'h77);
    @(negedge clk);
    cmp_en = 1'b0;
    rst_n = 1'b0;
    fclk = 1'b0;
    #1;
    check(valid == 0 && data == 0 && gcnt == 0 && lost == 0, "R8 reset mid-run", {valid, lost, gcnt}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R1 latency and R3 last-low capture with the bus changing at the edge
    hold_level(1'b0, 8'h3C, 8);
    drive(1'b1, 8'hA5);
    begin
      int first;
      first = 0;
      for (int i = 1; i <= 12; i++) begin
        @(negedge clk);
        if (valid && first == 0) begin
          first = i;
          check(data == 8'h3C, "R3 last-low word", data, 8'h3C);
        end
      end
      check(first == S + MP, "R1 latency", first, S + MP);
    end

    // R4 short high rejected
    hold_level(1'b0, 8'h11, 8);
    repeat (S + 2) @(negedge clk);
    v0 = n_valid; g0 = gcnt;
    drive(1'b1, 8'h22);
    hold_level(1'b1, 8'h22, MP - 2);
    hold_level(1'b0, 8'h22, 10);
    check(n_valid == v0, "R4 no strobe on short high", n_valid, v0);
    check(int'(gcnt) == g0 + 1, "R4 glitch counted", gcnt, g0 + 1);

    // R5 short low inside qualified high
    v0 = n_valid; g0 = gcnt;
    drive(1'b1, 8'h33);
    hold_level(1'b1, 8'h33, 7);
    drive(1'b0, 8'h33);
    hold_level(1'b1, 8'h44, 8);
    repeat (S + 2) @(negedge clk);
    check(n_valid == v0 + 1, "R5 dip ignored", n_valid, v0 + 1);
    check(int'(gcnt) == g0 + 1, "R5 dip counted", gcnt, g0 + 1);

    // R6 saturation
    for (int k = 0; k < 20; k++) begin
      hold_level(1'b0, 8'h55, 4);
      hold_level(1'b1, 8'h55, 1);
    end
    hold_level(1'b0, 8'h55, 6);
    check(gcnt == '1, "R6 saturated", gcnt, (1 << GW) - 1);

    // R7 stall then recovery
    hold_level(1'b0, 8'h66, TO + 10);
    check(lost == 1'b1, "R7 lost after stall", lost, 1);
    drive(1'b1, 8'h99);
    for (int i = 1; i <= S + MP; i++) @(negedge clk);
    check(valid == 1'b1 && lost == 1'b0, "R7 clear on strobe", {valid, lost}, 2);
    hold_level(1'b1, 8'h99, 4);
    hold_level(1'b0, 8'h99, 4);
    summary();
  end
endmodule